// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block holds the interrupt state of a two-wire serial bus controller. Ten source bit positions exist. Nine of them are implemented, and bit 8 is a permanent hole. Each implemented source is built as one of two kinds, chosen by a parameter:

- A level bit mirrors its condition.
- An edge bit latches when its source fires and holds until software clears it.

A mask register gates the status bits onto a single interrupt line. A mask bit of 1 blocks its source. Software never writes the mask directly. It writes ones to an enable offset to unblock sources, and ones to a separate disable offset to block them.

Register access is a simple single-cycle port. A write strobe goes with an address and a data word. Read data is a combinational function of the address. The protocol engine drives the source vector, one bit per event kind, and receives `irq_o`. The protocol engine and the bus fabric that carries the register port are outside this block.

Top module: `irq_bank`

## Requirements
- R1: Reads at address 0x10 return status and reads at 0x20 return the mask. Reads at the enable offset 0x24, the disable offset 0x28, or any other address return zero.
- R2: Reset behaviour:
  - Reset is synchronous and active low.
  - After reset, status is 0 and the mask is 0x2FF, so every implemented source is blocked.
  - `irq_o` is low after reset.
- R3: On an edge bit, writing 1 to a status bit at 0x10 clears it on the next clock. Writing 0 there leaves the bit unchanged.
- R4: Writing 1 to a bit at 0x24 clears that mask bit on the next clock. Zero bits leave the mask alone.
- R5: Writing 1 to a bit at 0x28 sets that mask bit on the next clock. Zero bits leave the mask alone.
- R6: A write to 0x20 does not change the mask.
- R7: Bit positions are:

  | Bit | Source |
  |---|---|
  | 0 | complete |
  | 1 | data |
  | 2 | no-acknowledge |
  | 3 | timeout |
  | 4 | slave ready |
  | 5 | receive overflow |
  | 6 | transmit overflow |
  | 7 | receive underflow |
  | 9 | arbitration lost |

  Bit 8 is unimplemented and always reads 0 in both status and mask.
- R8: An edge bit becomes 1 in the clock after its source is high. It stays 1 after the source drops, until it is cleared as in R3.
- R9: A level bit copies its source each clock, with one cycle of delay. A write-one-to-clear has no effect on it. By default the level bits are data (bit 1) and slave ready (bit 4).
- R10: `irq_o` is high exactly when some bit is 1 in status and 0 in the mask.
- R11: If an edge bit's source is high in the same cycle that a write-one-to-clear targets that bit, the bit is 1 after the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 10 | Write data, one bit per source |
| reg_rdata | output | 10 | Read data selected by `reg_addr` |
| src_i | input | 10 | Event and condition inputs from the protocol engine |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The block holds only two registered vectors, so any corrupted state shows within one clock.

- A wrong mask bit appears at the 0x20 read.
- A wrong status bit appears at the 0x10 read.
- Either fault also shows on `irq_o` whenever the bit is paired with an unmasked, set bit.

The riskiest cases are:

- a clear and an event landing together;
- level bits that must ignore a clear;
- the unimplemented bit 8, which must stay zero even under an all-ones source or disable write.

Each of these is driven and then read back through the register port.

// File: rtl/irq_bank_pkg.sv
// Shared constants for the interrupt register bank: register offsets,
// source bit positions and default build maps.
package irq_bank_pkg;
    localparam int unsigned NUM_SRC_DEF = 10;
    localparam int unsigned ADDR_W_DEF  = 8;

    // Register byte offsets
    localparam int unsigned OFF_STATUS  = 32'h10;
    localparam int unsigned OFF_MASK    = 32'h20;
    localparam int unsigned OFF_ENABLE  = 32'h24;
    localparam int unsigned OFF_DISABLE = 32'h28;

    // Source bit positions (decoded by the protocol engine and software)
    localparam int unsigned BIT_COMPLETE  = 0;
    localparam int unsigned BIT_DATA      = 1;
    localparam int unsigned BIT_NACK      = 2;
    localparam int unsigned BIT_TIMEOUT   = 3;
    localparam int unsigned BIT_SLV_READY = 4;
    localparam int unsigned BIT_RX_OVF    = 5;
    localparam int unsigned BIT_TX_OVF    = 6;
    localparam int unsigned BIT_RX_UNF    = 7;
    localparam int unsigned BIT_ARB_LOST  = 9;

    // Which positions exist, and which of those are level type
    localparam logic [NUM_SRC_DEF-1:0] IMPL_DEF  = 10'h2FF;
    localparam logic [NUM_SRC_DEF-1:0] LEVEL_DEF =
        (10'd1 << BIT_DATA) | (10'd1 << BIT_SLV_READY);
endpackage

// File: rtl/irq_stat_reg.sv
// Status register: one flop per source position.
// - Level positions copy their source.
// - Edge positions set on source and clear on a write-one.
// - A set in the same cycle as a clear wins.
// - Unimplemented positions are forced to zero.
// Assumes clr_i is already qualified by the status-address write decode.
module irq_stat_reg #(
    parameter int unsigned          NUM_SRC   = 10,
    parameter logic [NUM_SRC-1:0]   IMPL_MAP  = 10'h2FF,
    parameter logic [NUM_SRC-1:0]   LEVEL_MAP = 10'h012
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] stat_o
);
    logic [NUM_SRC-1:0] stat_d;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (LEVEL_MAP[i]) begin : g_level
            // Level type: follow the condition, clears have no effect
            always_comb stat_d[i] = src_i[i];
        end else begin : g_edge
            // Edge type: sticky, event wins over a same-cycle clear
            always_comb stat_d[i] = src_i[i] | (stat_o[i] & ~clr_i[i]);
        end
    end

    // Register the next status, keeping unimplemented positions at zero
    always_ff @(posedge clk) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= stat_d & IMPL_MAP;
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Mask register.
// - Set bits block their source.
// - Written only through the enable pulse (clears bits) and the disable
//   pulse (sets bits).
// - Resets to all implemented positions set.
// Assumes en_i and dis_i are never high together (one address per write).
module irq_mask_reg #(
    parameter int unsigned        NUM_SRC  = 10,
    parameter logic [NUM_SRC-1:0] IMPL_MAP = 10'h2FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               dis_i,
    input  logic [NUM_SRC-1:0] bits_i,
    output logic [NUM_SRC-1:0] mask_o
);
    logic [NUM_SRC-1:0] mask_d;

    // Apply the write-one enable or disable to the current mask
    always_comb begin
        mask_d = mask_o;
        if (en_i)       mask_d = mask_o & ~bits_i;
        else if (dis_i) mask_d = mask_o | bits_i;
    end

    // Register the mask, reset to fully blocked
    always_ff @(posedge clk) begin
        if (!rst_n) mask_o <= IMPL_MAP;
        else        mask_o <= mask_d & IMPL_MAP;
    end
endmodule

// File: rtl/irq_read_mux.sv
// Read data select.
// - Status and mask are readable.
// - Write-only and unmapped addresses return zero.
// Purely combinational.
module irq_read_mux #(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] stat_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] rdata_o
);
    import irq_bank_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

    // Pick the readable register for the current address
    always_comb begin
        if (addr_i == A_STAT)      rdata_o = stat_i;
        else if (addr_i == A_MASK) rdata_o = mask_i;
        else                       rdata_o = '0;
    end
endmodule

// File: rtl/irq_bank.sv
// Interrupt status and mask register bank (top).
// - Decodes the simple register port into a status clear, a mask enable
//   and a mask disable.
// - Combines unmasked status into irq_o.
// Assumes a single-cycle write strobe and combinational reads.
module irq_bank #(
    parameter int unsigned        NUM_SRC   = irq_bank_pkg::NUM_SRC_DEF,
    parameter int unsigned        ADDR_W    = irq_bank_pkg::ADDR_W_DEF,
    parameter logic [NUM_SRC-1:0] IMPL_MAP  = irq_bank_pkg::IMPL_DEF,
    parameter logic [NUM_SRC-1:0] LEVEL_MAP = irq_bank_pkg::LEVEL_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o
);
    import irq_bank_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFF_DISABLE);

    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] clr_v;
    logic               en_w;
    logic               dis_w;

    // Decode writes into the three write-one actions
    always_comb begin
        clr_v = (reg_wr && reg_addr == A_STAT) ? reg_wdata : '0;
        en_w  = reg_wr && (reg_addr == A_EN);
        dis_w = reg_wr && (reg_addr == A_DIS);
    end

    irq_stat_reg #(
        .NUM_SRC  (NUM_SRC),
        .IMPL_MAP (IMPL_MAP),
        .LEVEL_MAP(LEVEL_MAP)
    ) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .clr_i (clr_v),
        .stat_o(stat_q)
    );

    irq_mask_reg #(
        .NUM_SRC (NUM_SRC),
        .IMPL_MAP(IMPL_MAP)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_w),
        .dis_i (dis_w),
        .bits_i(reg_wdata),
        .mask_o(mask_q)
    );

    irq_read_mux #(
        .NUM_SRC(NUM_SRC),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .addr_i (reg_addr),
        .stat_i (stat_q),
        .mask_i (mask_q),
        .rdata_o(reg_rdata)
    );

    // Raise the request when any set status bit is unblocked
    always_comb irq_o = |(stat_q & ~mask_q);
endmodule

// File: rtl/irq_bank_chk.sv
// Property checker for irq_bank, attached by bind.
// Observes the ports and the two state vectors.
module irq_bank_chk #(
    parameter int unsigned        NUM_SRC   = 10,
    parameter int unsigned        ADDR_W    = 8,
    parameter logic [NUM_SRC-1:0] IMPL_MAP  = 10'h2FF,
    parameter logic [NUM_SRC-1:0] LEVEL_MAP = 10'h012
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_SRC-1:0] reg_wdata,
    input logic [NUM_SRC-1:0] src_i,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] stat_q,
    input logic [NUM_SRC-1:0] mask_q
);
    import irq_bank_pkg::*;

    localparam logic [NUM_SRC-1:0] EDGE_M = IMPL_MAP & ~LEVEL_MAP;
    localparam logic [NUM_SRC-1:0] LVL_M  = IMPL_MAP & LEVEL_MAP;

    logic st_wr, en_wr, dis_wr;
    always_comb begin
        st_wr  = reg_wr && reg_addr == ADDR_W'(OFF_STATUS);
        en_wr  = reg_wr && reg_addr == ADDR_W'(OFF_ENABLE);
        dis_wr = reg_wr && reg_addr == ADDR_W'(OFF_DISABLE);
    end

    // R3
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((stat_q & $past(reg_wdata & EDGE_M & ~src_i)) == '0));

    // R4
    mask_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> ((mask_q & $past(reg_wdata & IMPL_MAP)) == '0));

    // R5
    mask_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> ((mask_q & $past(reg_wdata & IMPL_MAP)) == $past(reg_wdata & IMPL_MAP)));

    // R7
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((stat_q | mask_q) & ~IMPL_MAP) == '0));

    // R8
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((($past(stat_q) & EDGE_M) & ~stat_q) == '0));

    // R9
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stat_q & LVL_M) == ($past(src_i) & LVL_M)));

    // R10
    irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == IMPL_MAP) |-> !irq_o);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & IMPL_MAP) != '0) |=> ((stat_q & $past(src_i & IMPL_MAP)) == $past(src_i & IMPL_MAP)));
endmodule

bind irq_bank irq_bank_chk #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .IMPL_MAP (IMPL_MAP),
    .LEVEL_MAP(LEVEL_MAP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .src_i    (src_i),
    .irq_o    (irq_o),
    .stat_q   (stat_q),
    .mask_q   (mask_q)
);

// File: tb/sim_irq_bank.sv
// Table-driven bench for irq_bank, followed by directed reset and address tests.
module sim_irq_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic [9:0] src_i = '0;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_bank u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .src_i    (src_i),
        .irq_o    (irq_o)
    );

    // Vector layout:
    // {wr, waddr[7:0], wdata[9:0], src[9:0], raddr[7:0], exp_rd[9:0], exp_irq}
    localparam logic [47:0] TBL [0:NV-1] = '{
        {1'b0, 8'h00, 10'h000, 10'h001, 8'h10, 10'h001, 1'b0}, // R8 complete latches, masked
        {1'b1, 8'h24, 10'h001, 10'h000, 8'h20, 10'h2FE, 1'b1}, // R4 enable bit 0
        {1'b1, 8'h10, 10'h000, 10'h000, 8'h10, 10'h001, 1'b1}, // R3 zero write no effect
        {1'b1, 8'h10, 10'h001, 10'h000, 8'h10, 10'h000, 1'b0}, // R3 clear
        {1'b0, 8'h00, 10'h000, 10'h012, 8'h10, 10'h012, 1'b0}, // R9 level bits follow
        {1'b1, 8'h10, 10'h012, 10'h012, 8'h10, 10'h012, 1'b0}, // R9 clear ignored
        {1'b1, 8'h24, 10'h010, 10'h000, 8'h10, 10'h000, 1'b0}, // R9 level drops
        {1'b0, 8'h00, 10'h000, 10'h010, 8'h10, 10'h010, 1'b1}, // R10 unmasked level
        {1'b1, 8'h28, 10'h010, 10'h000, 8'h20, 10'h2FE, 1'b0}, // R5 disable bit 4
        {1'b1, 8'h10, 10'h200, 10'h200, 8'h10, 10'h200, 1'b0}, // R11 event beats clear
        {1'b1, 8'h24, 10'h200, 10'h000, 8'h20, 10'h0FE, 1'b1}, // R4 enable bit 9
        {1'b1, 8'h20, 10'h3FF, 10'h000, 8'h20, 10'h0FE, 1'b1}, // R6 mask write ignored
        {1'b1, 8'h10, 10'h200, 10'h000, 8'h10, 10'h000, 1'b0}, // R3 clear bit 9
        {1'b0, 8'h00, 10'h000, 10'h3FF, 8'h10, 10'h2FF, 1'b1}, // R7 bit 8 never set
        {1'b1, 8'h28, 10'h3FF, 10'h000, 8'h20, 10'h2FF, 1'b0}, // R7 mask hole stays 0
        {1'b0, 8'h00, 10'h000, 10'h000, 8'h24, 10'h000, 1'b0}, // R1 enable reads 0
        {1'b0, 8'h00, 10'h000, 10'h000, 8'h28, 10'h000, 1'b0}, // R1 disable reads 0
        {1'b0, 8'h00, 10'h000, 10'h000, 8'h10, 10'h2ED, 1'b0}, // R8 edge bits held
        {1'b1, 8'h24, 10'h3FF, 10'h000, 8'h20, 10'h000, 1'b1}, // R10 all enabled
        {1'b1, 8'h10, 10'h3FF, 10'h000, 8'h10, 10'h000, 1'b0}  // R3 clear all
    };

    string tag_of [NV];

    task automatic check(input string tag, input string what,
                         input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%03h expected 0x%03h", tag, what, act, exp);
        end
    endtask

    task automatic read_chk(input logic [7:0] a, input string tag,
                            input logic [9:0] exp);
        reg_addr = a;
        #1;
        check(tag, "read", reg_rdata, exp);
    endtask

    initial begin
        tag_of = '{"R8", "R4", "R3", "R3", "R9", "R9", "R9", "R10", "R5", "R11",
                   "R4", "R6", "R3", "R7", "R7", "R1", "R1", "R8", "R10", "R3"};

        // Reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_chk(8'h10, "R2", 10'h000);
        read_chk(8'h20, "R2", 10'h2FF);
        check("R2", "irq", {9'd0, irq_o}, 10'h000);

        // Table walk: drive in the low phase, one edge, read in the next low phase
        for (int k = 0; k < NV; k++) begin
            reg_wr    = TBL[k][47];
            reg_addr  = TBL[k][46:39];
            reg_wdata = TBL[k][38:29];
            src_i     = TBL[k][28:19];
            @(negedge clk);
            reg_wr = 1'b0;
            src_i  = '0;
            reg_addr = TBL[k][18:11];
            #1;
            check(tag_of[k], "read", reg_rdata, TBL[k][10:1]);
            check(tag_of[k], "irq", {9'd0, irq_o}, {9'd0, TBL[k][0]});
        end

        // R1 unmapped address reads zero
        read_chk(8'h00, "R1", 10'h000);
        read_chk(8'h14, "R1", 10'h000);

        // R2 reset in mid-run restores blocked mask and clear status
        reg_wr = 1'b1;
        reg_addr = 8'h24;
        reg_wdata = 10'h3FF;
        src_i = 10'h001;
        @(negedge clk);
        reg_wr = 1'b0;
        src_i = '0;
        check("R2", "irq before reset", {9'd0, irq_o}, 10'h001);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_chk(8'h10, "R2", 10'h000);
        read_chk(8'h20, "R2", 10'h2FF);
        check("R2", "irq", {9'd0, irq_o}, 10'h000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule